// File: doc/BRIEF.md
# Descriptor Ring Controller with Interrupt Sources

This block owns a table of two-word buffer descriptors shared by a transmit ring and a receive ring. A programmable split count divides the table: transmit descriptors sit at indices below the count, receive descriptors at and above it. Software fills descriptors through a word-addressed host port. The block keeps the current transmit and receive positions. It decides when a transmit may begin and whether an arriving frame is accepted. When a frame completes, it rewrites the descriptor's first word, moves the ring position forward or wraps it, and records interrupt events.

Frame data movement is outside the block. A data mover sees a `tx_start` pulse with `tx_index`, and it answers with a `tx_done` pulse. The receive side presents `rx_frame` together with the frame length and the nine receive status bits. The host port uses word address 2*i for the length-and-flags word of descriptor i and 2*i+1 for its buffer pointer. Four control targets are reached through `ctl_sel`: 0 is the mode register (bit 0 receive enable, bit 1 transmit enable, bit 2 soft reset), 1 is the interrupt source register (write 1 to clear), 2 is the interrupt mask, and 3 is the transmit count.

Top module: `bdr_ring_ctrl`

## Requirements
- R1: After reset the transmit index is 0, the receive index is 64, the interrupt source is 0, `irq` is 0, and neither `tx_start` nor `rx_ready` is asserted.
- R2: `tx_start` is asserted only while transmit is enabled, the transmit count is nonzero, the current transmit descriptor has its ready bit (bit 15) set and its length field (bits 31:16) exceeds 4, and no transmit is outstanding. It lasts one cycle per transmit.
- R3: On `tx_done` the transmit index becomes 0 if the descriptor's wrap bit (bit 13) is set or if index+1 reaches the transmit count, and becomes index+1 otherwise. The descriptor's bit 15 and bits 8:0 are cleared and its other bits are kept.
- R4: A rising transmit enable sets the transmit index to 0. A rising receive enable sets the receive index to the transmit count.
- R5: An accepted frame on an empty descriptor (bit 15 set) rewrites its first word as {length, 0, old bits 14:9, status bits 8:0}. The receive index then becomes the transmit count if bit 13 was set or the index was 127, and becomes index+1 otherwise.
- R6: An accepted frame on a non-empty descriptor is dropped. The descriptor and the receive index stay unchanged and source bit 4 (busy) is set.
- R7: `rx_ready` is high exactly when receive is enabled and the count is below 128. A frame presented while `rx_ready` is low changes no descriptor, index or source bit.
- R8: Completing a descriptor with its irq bit (bit 14) set raises source bit 0 for transmit or source bit 2 for receive. Without that bit, no source bit is raised.
- R9: A write to the source register clears the bits written as 1. A source event in the same cycle wins over the clear.
- R10: `irq` is the OR of source AND mask, registered, so it follows a source or mask change one clock later.
- R11: A transmit count write with a value of 128 or more is ignored.
- R12: A mode write that takes bit 2 from 0 to 1 restores the count to 64, the indices to their reset values, and the source and mask to 0. The mode register takes the written value. Rewriting bit 2 while it is already 1 resets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_desc_we | input | 1 | Host write strobe for the descriptor table |
| host_desc_addr | input | 8 | Host word address into the table |
| host_desc_wdata | input | 32 | Host write data |
| host_desc_rdata | output | 32 | Table word at `host_desc_addr` |
| ctl_we | input | 1 | Control write strobe |
| ctl_sel | input | 2 | Control target: 0 mode, 1 source clear, 2 mask, 3 transmit count |
| ctl_wdata | input | 8 | Control write data |
| tx_start | output | 1 | Transmit may begin on descriptor `tx_index` |
| tx_index | output | 7 | Current transmit descriptor |
| tx_done | input | 1 | Outstanding transmit finished |
| rx_ready | output | 1 | Receive frames are accepted |
| rx_index | output | 7 | Current receive descriptor |
| rx_frame | input | 1 | A received frame completes this cycle |
| rx_len | input | 16 | Length of the received frame |
| rx_stat | input | 9 | Receive status bits for the descriptor |
| int_src | output | 5 | Interrupt source register |
| irq | output | 1 | Level interrupt |

## Verification
The case hardest to reach from the ports is the receive index wrapping at the last table entry without a wrap bit. Reaching it takes 64 back-to-back completions from the default start, so the stimulus prepares every receive descriptor as empty and then drives a directed run across the whole ring. A second hard case is a source clear that lands in the same cycle as a completion event. The bench reaches it by driving a control write and `rx_frame` on the same clock edge. Seeded random frames then mix empty and non-empty descriptors, wrap and irq bits, and each result is compared with a model of the index and descriptor rewrite kept in the bench.

// File: rtl/bdr_pkg.sv
package bdr_pkg;

  typedef enum logic [1:0] {
    CSEL_MODE    = 2'd0,
    CSEL_SRC_CLR = 2'd1,
    CSEL_MASK    = 2'd2,
    CSEL_TX_CNT  = 2'd3
  } ctl_sel_e;

  localparam int SRC_W    = 5;
  localparam int SRC_TXB  = 0;
  localparam int SRC_RXB  = 2;
  localparam int SRC_BUSY = 4;

  localparam int MODE_W   = 3;
  localparam int MODE_RXE = 0;
  localparam int MODE_TXE = 1;
  localparam int MODE_RST = 2;

  localparam int STAT_W   = 9;

  // transmit ring step: wrap bit or reaching the count returns to entry 0
  function automatic int unsigned tx_step(int unsigned idx, logic wrap, int unsigned cnt);
    if (wrap || (idx + 1 >= cnt)) return 0;
    return idx + 1;
  endfunction

  // receive ring step: wrap bit or last table entry returns to the split count
  function automatic int unsigned rx_step(int unsigned idx, logic wrap, int unsigned cnt,
                                          int unsigned last);
    if (wrap || (idx == last)) return cnt;
    return idx + 1;
  endfunction

  // transmit close-out: drop ready and every status bit
  function automatic logic [31:0] tx_close(logic [31:0] w);
    return w & ~32'h0000_81FF;
  endfunction

endpackage

// File: rtl/bdr_desc_table.sv
module bdr_desc_table #(
  parameter int NUM_DESC = 128,
  parameter int IDX_W    = $clog2(NUM_DESC),
  parameter int AW       = IDX_W + 1
) (
  input  logic             clk,
  input  logic             host_we,
  input  logic [AW-1:0]    host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic [IDX_W-1:0] tx_idx,
  input  logic             tx_we,
  input  logic [31:0]      tx_wdata,
  output logic [31:0]      tx_word0,
  input  logic [IDX_W-1:0] rx_idx,
  input  logic             rx_we,
  input  logic [31:0]      rx_wdata,
  output logic [6:0]       rx_head
);
  localparam int WORDS = 2 * NUM_DESC;

  logic [31:0] mem [WORDS];
  logic [AW-1:0] tx_a, rx_a;
  logic host_hit, tx_lose;

  assign tx_a = {tx_idx, 1'b0};
  assign rx_a = {rx_idx, 1'b0};

  // completion writes take precedence over the host on a shared word
  assign host_hit = (tx_we && host_addr == tx_a) || (rx_we && host_addr == rx_a);
  assign tx_lose  = rx_we && (rx_a == tx_a);

  always_ff @(posedge clk) begin
    if (host_we && !host_hit) mem[host_addr] <= host_wdata;
    if (tx_we && !tx_lose)    mem[tx_a]      <= tx_wdata;
    if (rx_we)                mem[rx_a]      <= rx_wdata;
  end

  assign host_rdata = mem[host_addr];
  assign tx_word0   = mem[tx_a];
  assign rx_head    = mem[rx_a][15:9];
endmodule

// File: rtl/bdr_irq.sv
module bdr_irq #(
  parameter int SRC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [SRC_W-1:0] set_vec,
  input  logic             clr_we,
  input  logic [SRC_W-1:0] clr_vec,
  input  logic             mask_we,
  input  logic [SRC_W-1:0] mask_vec,
  output logic [SRC_W-1:0] src,
  output logic             irq
);
  logic [SRC_W-1:0] src_q, mask_q, clr_eff;
  logic             irq_q;

  assign clr_eff = clr_we ? clr_vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (soft_rst) begin
        src_q  <= '0;
        mask_q <= '0;
      end else begin
        src_q <= (src_q & ~clr_eff) | set_vec;
        if (mask_we) mask_q <= mask_vec;
      end
      irq_q <= |(src_q & mask_q);
    end
  end

  assign src = src_q;
  assign irq = irq_q;

  assert_irq_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == $past(|(src_q & mask_q)));

  assert_clear_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !soft_rst) |=> ((src_q & $past(clr_vec & ~set_vec)) == '0));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec && !soft_rst) |=> ((src_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/bdr_index_ctl.sv
module bdr_index_ctl
  import bdr_pkg::*;
#(
  parameter int NUM_DESC  = 128,
  parameter int IDX_W     = $clog2(NUM_DESC),
  parameter int CNT_W     = IDX_W + 1,
  parameter int RESET_CNT = NUM_DESC / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              tx_en_rise,
  input  logic              rx_en_rise,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [31:0]       tx_word0,
  input  logic [6:0]        rx_head,
  input  logic              tx_done,
  input  logic              rx_frame,
  input  logic [15:0]       rx_len,
  input  logic [STAT_W-1:0] rx_stat,
  output logic              tx_start,
  output logic              rx_ready,
  output logic [IDX_W-1:0]  tx_idx,
  output logic [IDX_W-1:0]  rx_idx,
  output logic              tx_we,
  output logic [31:0]       tx_wdata,
  output logic              rx_we,
  output logic [31:0]       rx_wdata,
  output logic [SRC_W-1:0]  set_vec
);
  localparam int LAST = NUM_DESC - 1;

  logic [IDX_W-1:0] tx_idx_q, rx_idx_q;
  logic tx_busy_q;
  logic tx_len_ok, tx_commit, rx_take, rx_commit, rx_drop;

  assign tx_len_ok = tx_word0[31:16] > 16'd4;
  assign tx_start  = tx_en && (cnt != '0) && tx_word0[15] && tx_len_ok &&
                     !tx_busy_q && !soft_rst;
  assign tx_commit = tx_done && tx_busy_q && !soft_rst;

  assign rx_ready  = rx_en && (32'(cnt) < NUM_DESC);
  assign rx_take   = rx_frame && rx_ready && !soft_rst;
  assign rx_commit = rx_take && rx_head[6];
  assign rx_drop   = rx_take && !rx_head[6];

  assign tx_we    = tx_commit;
  assign tx_wdata = tx_close(tx_word0);
  assign rx_we    = rx_commit;
  assign rx_wdata = {rx_len, 1'b0, rx_head[5:0], rx_stat};

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_TXB]  = tx_commit && tx_word0[14];
    set_vec[SRC_RXB]  = rx_commit && rx_head[5];
    set_vec[SRC_BUSY] = rx_drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_idx_q  <= '0;
      rx_idx_q  <= IDX_W'(RESET_CNT);
      tx_busy_q <= 1'b0;
    end else if (soft_rst) begin
      tx_idx_q  <= '0;
      rx_idx_q  <= IDX_W'(RESET_CNT);
      tx_busy_q <= 1'b0;
    end else begin
      if (tx_start)       tx_busy_q <= 1'b1;
      else if (tx_commit) tx_busy_q <= 1'b0;

      if (tx_en_rise)     tx_idx_q <= '0;
      else if (tx_commit) tx_idx_q <= IDX_W'(tx_step(32'(tx_idx_q), tx_word0[13], 32'(cnt)));

      if (rx_en_rise)     rx_idx_q <= IDX_W'(cnt);
      else if (rx_commit) rx_idx_q <= IDX_W'(rx_step(32'(rx_idx_q), rx_head[4], 32'(cnt), LAST));
    end
  end

  assign tx_idx = tx_idx_q;
  assign rx_idx = rx_idx_q;

  assert_tx_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  assert_tx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_commit && !tx_en_rise) |=> (tx_idx_q == '0 || tx_idx_q == $past(tx_idx_q) + 1'b1));

  assert_rx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_commit |=> (rx_idx_q == IDX_W'($past(cnt)) || rx_idx_q == $past(rx_idx_q) + 1'b1));

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> $stable(rx_idx_q));

  assert_rx_off_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame && !rx_ready && !rx_en_rise && !soft_rst) |=> $stable(rx_idx_q));
endmodule

// File: rtl/bdr_ring_ctrl.sv
module bdr_ring_ctrl
  import bdr_pkg::*;
#(
  parameter int NUM_DESC  = 128,
  parameter int RESET_CNT = NUM_DESC / 2,
  parameter int IDX_W     = $clog2(NUM_DESC),
  parameter int AW        = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_desc_we,
  input  logic [AW-1:0]    host_desc_addr,
  input  logic [31:0]      host_desc_wdata,
  output logic [31:0]      host_desc_rdata,
  input  logic             ctl_we,
  input  logic [1:0]       ctl_sel,
  input  logic [7:0]       ctl_wdata,
  output logic             tx_start,
  output logic [IDX_W-1:0] tx_index,
  input  logic             tx_done,
  output logic             rx_ready,
  output logic [IDX_W-1:0] rx_index,
  input  logic             rx_frame,
  input  logic [15:0]      rx_len,
  input  logic [8:0]       rx_stat,
  output logic [4:0]       int_src,
  output logic             irq
);
  localparam int CNT_W = IDX_W + 1;

  ctl_sel_e          sel;
  logic [MODE_W-1:0] mode_q, mode_set;
  logic [CNT_W-1:0]  cnt_q;
  logic mode_wr, cnt_wr, cnt_ok, soft_rst, tx_en_rise, rx_en_rise;

  logic [31:0]      tx_word0, tx_wdata, rx_wdata;
  logic [6:0]       rx_head;
  logic             tx_we, rx_we;
  logic [SRC_W-1:0] set_vec;

  assign sel        = ctl_sel_e'(ctl_sel);
  assign mode_wr    = ctl_we && sel == CSEL_MODE;
  assign cnt_wr     = ctl_we && sel == CSEL_TX_CNT;
  assign cnt_ok     = 32'(ctl_wdata) < NUM_DESC;
  assign mode_set   = ctl_wdata[MODE_W-1:0] & ~mode_q;
  assign soft_rst   = mode_wr && mode_set[MODE_RST];
  assign tx_en_rise = mode_wr && mode_set[MODE_TXE];
  assign rx_en_rise = mode_wr && mode_set[MODE_RXE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cnt_q  <= CNT_W'(RESET_CNT);
    end else begin
      if (mode_wr) mode_q <= ctl_wdata[MODE_W-1:0];
      if (soft_rst)              cnt_q <= CNT_W'(RESET_CNT);
      else if (cnt_wr && cnt_ok) cnt_q <= CNT_W'(ctl_wdata);
    end
  end

  bdr_desc_table #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .AW(AW)) u_table (
    .clk        (clk),
    .host_we    (host_desc_we),
    .host_addr  (host_desc_addr),
    .host_wdata (host_desc_wdata),
    .host_rdata (host_desc_rdata),
    .tx_idx     (tx_index),
    .tx_we      (tx_we),
    .tx_wdata   (tx_wdata),
    .tx_word0   (tx_word0),
    .rx_idx     (rx_index),
    .rx_we      (rx_we),
    .rx_wdata   (rx_wdata),
    .rx_head    (rx_head)
  );

  bdr_index_ctl #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .CNT_W(CNT_W),
                  .RESET_CNT(RESET_CNT)) u_index (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .tx_en      (mode_q[MODE_TXE]),
    .rx_en      (mode_q[MODE_RXE]),
    .tx_en_rise (tx_en_rise),
    .rx_en_rise (rx_en_rise),
    .cnt        (cnt_q),
    .tx_word0   (tx_word0),
    .rx_head    (rx_head),
    .tx_done    (tx_done),
    .rx_frame   (rx_frame),
    .rx_len     (rx_len),
    .rx_stat    (rx_stat),
    .tx_start   (tx_start),
    .rx_ready   (rx_ready),
    .tx_idx     (tx_index),
    .rx_idx     (rx_index),
    .tx_we      (tx_we),
    .tx_wdata   (tx_wdata),
    .rx_we      (rx_we),
    .rx_wdata   (rx_wdata),
    .set_vec    (set_vec)
  );

  bdr_irq #(.SRC_W(SRC_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .set_vec  (set_vec),
    .clr_we   (ctl_we && sel == CSEL_SRC_CLR),
    .clr_vec  (ctl_wdata[SRC_W-1:0]),
    .mask_we  (ctl_we && sel == CSEL_MASK),
    .mask_vec (ctl_wdata[SRC_W-1:0]),
    .src      (int_src),
    .irq      (irq)
  );

  assert_cnt_guard_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !cnt_ok) |=> $stable(cnt_q));

  assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_index == '0 && rx_index == IDX_W'(RESET_CNT) && int_src == '0 &&
                  cnt_q == CNT_W'(RESET_CNT)));
endmodule

// File: tb/bdr_ring_ctrl_tb_top.sv
module bdr_ring_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_desc_we = 1'b0;
  logic [7:0]  host_desc_addr = '0;
  logic [31:0] host_desc_wdata = '0;
  logic [31:0] host_desc_rdata;
  logic        ctl_we = 1'b0;
  logic [1:0]  ctl_sel = '0;
  logic [7:0]  ctl_wdata = '0;
  logic        tx_start;
  logic [6:0]  tx_index;
  logic        tx_done = 1'b0;
  logic        rx_ready;
  logic [6:0]  rx_index;
  logic        rx_frame = 1'b0;
  logic [15:0] rx_len = '0;
  logic [8:0]  rx_stat = '0;
  logic [4:0]  int_src;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bdr_ring_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_desc_we(host_desc_we), .host_desc_addr(host_desc_addr),
    .host_desc_wdata(host_desc_wdata), .host_desc_rdata(host_desc_rdata),
    .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
    .tx_start(tx_start), .tx_index(tx_index), .tx_done(tx_done),
    .rx_ready(rx_ready), .rx_index(rx_index), .rx_frame(rx_frame),
    .rx_len(rx_len), .rx_stat(rx_stat), .int_src(int_src), .irq(irq)
  );

  // bench-side model of the requirements
  function automatic logic [31:0] exp_rx_word(logic [31:0] old, logic [15:0] len, logic [8:0] st);
    logic [31:0] w;
    w = old;
    w[31:16] = len;
    w[15]    = 1'b0;
    w[8:0]   = st;
    return w;
  endfunction

  function automatic int exp_rx_next(int idx, logic wrap, int cnt);
    if (wrap) return cnt;
    if (idx == 127) return cnt;
    return idx + 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctl(input logic [1:0] s, input logic [7:0] d);
    ctl_we = 1'b1; ctl_sel = s; ctl_wdata = d;
    tick;
    ctl_we = 1'b0;
  endtask

  task automatic wdesc(input int idx, input logic [31:0] w0);
    host_desc_we = 1'b1; host_desc_addr = 8'(2 * idx); host_desc_wdata = w0;
    tick;
    host_desc_we = 1'b0;
  endtask

  task automatic rdesc(input int idx, output logic [31:0] v);
    host_desc_addr = 8'(2 * idx);
    #1;
    v = host_desc_rdata;
  endtask

  task automatic tx_finish;
    tx_done = 1'b1;
    tick;
    tx_done = 1'b0;
  endtask

  task automatic rx_push(input logic [15:0] len, input logic [8:0] st);
    rx_frame = 1'b1; rx_len = len; rx_stat = st;
    tick;
    rx_frame = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

  initial begin
    logic [31:0] w;
    int mdl_rx;
    void'($urandom(32'h0BD5_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 tx_index", 32'(tx_index), 0);
    chk("R1 rx_index", 32'(rx_index), 64);
    chk("R1 int_src", 32'(int_src), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 tx_start", 32'(tx_start), 0);
    chk("R1 rx_ready", 32'(rx_ready), 0);

    ctl(2'd2, 8'h15);
    wdesc(0, 32'h003C_C000);
    chk("R2 no start while disabled", 32'(tx_start), 0);
    ctl(2'd0, 8'h02);
    chk("R2 start when enabled", 32'(tx_start), 1);
    chk("R4 tx index at enable", 32'(tx_index), 0);
    tick;
    chk("R2 single start pulse", 32'(tx_start), 0);
    tx_finish;
    chk("R3 tx index advance", 32'(tx_index), 1);
    rdesc(0, w);
    chk("R3 ready cleared", w, 32'h003C_4000);
    chk("R8 tx irq source", 32'(int_src), 32'h01);
    chk("R10 irq lags source", 32'(irq), 0);
    tick;
    chk("R10 irq after one clock", 32'(irq), 1);
    ctl(2'd1, 8'h01);
    chk("R9 clear by one", 32'(int_src), 0);
    chk("R10 irq still high one clock", 32'(irq), 1);
    tick;
    chk("R10 irq falls", 32'(irq), 0);

    wdesc(1, 32'h0004_8000);
    chk("R2 length 4 blocked", 32'(tx_start), 0);
    wdesc(1, 32'h0005_81FF);
    chk("R2 length 5 starts", 32'(tx_start), 1);
    tick;
    tx_finish;
    rdesc(1, w);
    chk("R3 status bits cleared", w, 32'h0005_0000);
    chk("R8 no irq flag no source", 32'(int_src), 0);
    chk("R3 index 2", 32'(tx_index), 2);

    wdesc(2, 32'h000A_A000);
    tick;
    tx_finish;
    chk("R3 wrap bit to zero", 32'(tx_index), 0);

    ctl(2'd3, 8'd1);
    wdesc(0, 32'h0008_8000);
    tick;
    tx_finish;
    chk("R3 wrap at count", 32'(tx_index), 0);
    ctl(2'd3, 8'd0);
    wdesc(0, 32'h0008_8000);
    chk("R2 zero count blocks", 32'(tx_start), 0);
    ctl(2'd3, 8'd2);
    chk("R2 nonzero count starts", 32'(tx_start), 1);
    tick;
    tx_finish;
    chk("R3 index below count", 32'(tx_index), 1);
    ctl(2'd0, 8'h00);

    // R11 out of range counts ignored, observed via receive start index
    ctl(2'd3, 8'h80);
    ctl(2'd0, 8'h01);
    chk("R11 count 0x80 ignored", 32'(rx_index), 2);
    ctl(2'd0, 8'h00);
    ctl(2'd3, 8'hC5);
    ctl(2'd0, 8'h01);
    chk("R11 count 0xC5 ignored", 32'(rx_index), 2);
    ctl(2'd0, 8'h00);
    ctl(2'd3, 8'h40);
    ctl(2'd0, 8'h01);
    chk("R4 rx index at count", 32'(rx_index), 64);
    chk("R7 rx_ready when enabled", 32'(rx_ready), 1);

    // R6 busy
    wdesc(64, 32'h0000_0000);
    rx_push(16'd60, 9'h000);
    chk("R6 busy source", 32'(int_src), 32'h10);
    chk("R6 index held", 32'(rx_index), 64);
    rdesc(64, w);
    chk("R6 descriptor untouched", w, 32'h0000_0000);
    ctl(2'd1, 8'h1F);

    // R5 directed full ring walk, last entry wraps without a wrap bit
    for (int i = 64; i < 128; i++) wdesc(i, 32'hABCD_9FFF);
    for (int i = 64; i < 128; i++) begin
      rx_push(16'(i), 9'(i) ^ 9'h155);
      rdesc(i, w);
      chk("R5 rx word", w, exp_rx_word(32'hABCD_9FFF, 16'(i), 9'(i) ^ 9'h155));
      chk("R5 rx index", 32'(rx_index), 32'(exp_rx_next(i, 1'b0, 64)));
    end
    chk("R8 no rx irq flag", 32'(int_src), 0);

    // random mix of empty/full descriptors with wrap and irq bits
    mdl_rx = 64;
    for (int n = 0; n < 60; n++) begin
      logic [31:0] r, old, rf;
      logic emp, irqf, wrapf;
      logic [4:0] exp_src;
      r = $urandom;
      rf = $urandom;
      emp = (r[6:4] != 3'd0);
      irqf = r[0];
      wrapf = (r[3:1] == 3'd0);
      old = {r[31:16], emp, irqf, wrapf, r[12:0]};
      wdesc(mdl_rx, old);
      rx_push(rf[15:0], rf[24:16]);
      rdesc(mdl_rx, w);
      if (emp) begin
        chk("R5 random rx word", w, exp_rx_word(old, rf[15:0], rf[24:16]));
        mdl_rx = exp_rx_next(mdl_rx, wrapf, 64);
        exp_src = irqf ? 5'h04 : 5'h00;
        chk("R8 random rx source", 32'(int_src), 32'(exp_src));
      end else begin
        chk("R6 random drop word", w, old);
        chk("R6 random busy", 32'(int_src), 32'h10);
      end
      chk("R5 random rx index", 32'(rx_index), 32'(mdl_rx));
      ctl(2'd1, 8'h1F);
    end

    // R7 receive disabled
    ctl(2'd0, 8'h00);
    chk("R7 rx_ready low", 32'(rx_ready), 0);
    wdesc(mdl_rx, 32'h0000_C000);
    rx_push(16'd99, 9'h1AA);
    rdesc(mdl_rx, w);
    chk("R7 descriptor unchanged", w, 32'h0000_C000);
    chk("R7 index unchanged", 32'(rx_index), 32'(mdl_rx));
    chk("R7 no source", 32'(int_src), 0);

    // R9 set beats clear in the same cycle
    ctl(2'd0, 8'h01);
    wdesc(64, 32'h0000_C000);
    ctl_we = 1'b1; ctl_sel = 2'd1; ctl_wdata = 8'h04;
    rx_frame = 1'b1; rx_len = 16'd7; rx_stat = 9'h000;
    tick;
    ctl_we = 1'b0; rx_frame = 1'b0;
    chk("R9 set wins over clear", 32'(int_src), 32'h04);

    // R12 soft reset on rising bit 2
    ctl(2'd3, 8'd16);
    chk("R12 precondition tx index", 32'(tx_index), 1);
    ctl(2'd0, 8'h05);
    chk("R12 tx index reset", 32'(tx_index), 0);
    chk("R12 rx index reset", 32'(rx_index), 64);
    chk("R12 source reset", 32'(int_src), 0);
    ctl(2'd0, 8'h04);
    ctl(2'd0, 8'h05);
    chk("R12 count restored", 32'(rx_index), 64);
    wdesc(64, 32'h0000_C000);
    rx_push(16'd3, 9'h000);
    chk("R12 source after reset", 32'(int_src), 32'h04);
    ctl(2'd0, 8'h05);
    chk("R12 no reset without rise", 32'(int_src), 32'h04);
    tick;
    chk("R12 mask cleared", 32'(irq), 0);

    finish_run;
  end
endmodule